// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block restores packed BCD form to an 8-bit accumulator after a plain binary addition or subtraction of two packed BCD operands. It receives the raw accumulator together with three flags left by the preceding operation: the subtract indicator, the half-carry out of bit 3 and the carry out of bit 7. It returns the corrected accumulator and a complete flag byte.

The subtract indicator picks one of two correction paths. The addition path adds 6 and/or 0x60. The subtraction path removes them. Each path has its own half-carry and carry rules. On the addition path the high-digit test looks at the value after the low-digit correction has been applied. On the subtraction path the high-digit test looks at the raw accumulator.

The correction itself is combinational. A parameter places an optional register on the outputs, giving one cycle of latency.

Top module: `bcd_adjust`

## Requirements
- R1: The flag byte places sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 are always 0. The subtract bit equals `sub_in`, which selects the subtraction path when 1 and the addition path when 0.
- R2: Addition path, low digit. If the low nibble of `acc_in` is 10 or more, 6 is added and half-carry out is 1. Otherwise, if `half_in` is 1, 6 is added and half-carry out is 0. Otherwise nothing is added and half-carry out is 0.
- R3: Addition path, high digit. If the value after the low-digit step is 0xA0 or more, or `carry_in` is 1, then 0x60 is added and carry out is 1. Otherwise carry out is 0.
- R4: Subtraction path, high digit. If `acc_in` is above 0x99, or `carry_in` is 1, then 0x60 is subtracted and carry out is 1. Carry out is also 1 when the low-digit step takes the value below zero while `half_in` is 0. In every other case carry out is 0.
- R5: Subtraction path, low digit. If the low nibble is above 9, or `half_in` is 1, 6 is subtracted. In that case half-carry out is 1 only when the low nibble is below 6. In all other cases half-carry out is 0.
- R6: `acc_out` is the low 8 bits of the corrected value. Sign is bit 7 of `acc_out`. Zero is 1 when `acc_out` is 0x00. Parity is 1 when `acc_out` has an even number of one bits.
- R7: When no condition of R2 to R5 applies, `acc_out` equals `acc_in`, and half-carry and carry out are 0.
- R8: With `REG_OUT`=1 (the default), the outputs show the result for the inputs present at the previous rising clock edge. While `rst_n` is low, both outputs are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| acc_in | input | 8 | Accumulator value before adjustment |
| sub_in | input | 1 | Previous operation was a subtraction |
| half_in | input | 1 | Incoming half-carry |
| carry_in | input | 1 | Incoming carry |
| acc_out | output | 8 | Adjusted accumulator |
| flags_out | output | 8 | Resulting flag byte (layout in R1) |

## Verification
The assertions treat every combination of accumulator and flags as legal. They make no assumption that the inputs came from a real BCD addition or subtraction, so they must hold even for out-of-range digits and for flag pairs that no real operation produces.

The stimulus meets this by sweeping all 2048 combinations of `acc_in`, `sub_in`, `half_in` and `carry_in` after the hand-worked table. The checks on the registered outputs therefore cover every case the properties quantify over, including the negative intermediates of the subtraction path.

// File: rtl/bcd_adjust_pkg.sv
package bcd_adjust_pkg;

  localparam int ACC_W  = 8;
  localparam int WIDE_W = ACC_W + 2;   // signed headroom for range and sign tests
  localparam int NIB_W  = 4;

  // flag byte bit positions
  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_HALF  = 4;
  localparam int FB_PAR   = 2;
  localparam int FB_SUB   = 1;
  localparam int FB_CARRY = 0;

  localparam logic [NIB_W-1:0]   LO_ADD_LIMIT = 4'd10;
  localparam logic [NIB_W-1:0]   LO_SUB_LIMIT = 4'd9;
  localparam logic [NIB_W-1:0]   LO_HALF_LIM  = 4'd6;
  localparam logic [ACC_W-1:0]   HI_SUB_LIMIT = 8'h99;
  localparam logic [ACC_W-1:0]   LO_STEP      = 8'h06;
  localparam logic [ACC_W-1:0]   HI_STEP      = 8'h60;

  typedef logic signed [WIDE_W-1:0] wide_t;
  typedef logic [ACC_W-1:0]         acc_t;

  localparam wide_t HI_ADD_LIMIT = wide_t'(10'sd160);

  function automatic wide_t widen(input acc_t v);
    return $signed({2'b00, v});
  endfunction

  function automatic wide_t step_if(input logic en, input acc_t amount);
    return en ? widen(amount) : wide_t'(0);
  endfunction

  function automatic logic even_parity(input acc_t v);
    return ~(^v);
  endfunction

  function automatic acc_t build_flags(input acc_t res, input logic h,
                                       input logic n, input logic c);
    acc_t f;
    f            = '0;
    f[FB_SIGN]   = res[ACC_W-1];
    f[FB_ZERO]   = (res == '0);
    f[FB_HALF]   = h;
    f[FB_PAR]    = even_parity(res);
    f[FB_SUB]    = n;
    f[FB_CARRY]  = c;
    return f;
  endfunction

endpackage

// File: rtl/bcd_add_path.sv
module bcd_add_path
  import bcd_adjust_pkg::*;
(
  input  acc_t  acc,
  input  logic  half,
  input  logic  carry,
  output wide_t val,
  output logic  lo_hit,    // low digit out of range: +6 with half-carry set
  output logic  lo_adj,    // +6 applied for any reason
  output logic  hi_hit     // +0x60 applied, carry set
);
  wide_t mid;

  always_comb begin
    lo_hit = (acc[NIB_W-1:0] >= LO_ADD_LIMIT);
    lo_adj = lo_hit | half;
    mid    = widen(acc) + step_if(lo_adj, LO_STEP);
    hi_hit = (mid >= HI_ADD_LIMIT) | carry;
    val    = mid + step_if(hi_hit, HI_STEP);
  end
endmodule

// File: rtl/bcd_sub_path.sv
module bcd_sub_path
  import bcd_adjust_pkg::*;
(
  input  acc_t  acc,
  input  logic  half,
  input  logic  carry,
  output wide_t val,
  output logic  hi_hit,    // -0x60 applied, carry set
  output logic  lo_adj,    // -6 applied
  output logic  half_set,  // -6 applied on a low digit below 6
  output logic  borrow     // went negative after -6 with no incoming half-carry
);
  wide_t mid;

  always_comb begin
    hi_hit   = (acc > HI_SUB_LIMIT) | carry;
    mid      = widen(acc) - step_if(hi_hit, HI_STEP);
    lo_adj   = (acc[NIB_W-1:0] > LO_SUB_LIMIT) | half;
    half_set = lo_adj & (acc[NIB_W-1:0] < LO_HALF_LIM);
    val      = mid - step_if(lo_adj, LO_STEP);
    borrow   = lo_adj & (val < 0) & ~half;
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_adjust_pkg::*;
(
  input  logic  sub,
  input  wide_t add_val,
  input  logic  add_h,
  input  logic  add_c,
  input  wide_t sub_val,
  input  logic  sub_h,
  input  logic  sub_c,
  output acc_t  res,
  output acc_t  flags
);
  logic h_sel;
  logic c_sel;

  always_comb begin
    res   = sub ? sub_val[ACC_W-1:0] : add_val[ACC_W-1:0];
    h_sel = sub ? sub_h : add_h;
    c_sel = sub ? sub_c : add_c;
    flags = build_flags(res, h_sel, sub, c_sel);
  end
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage
  import bcd_adjust_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  acc_t d_acc,
  input  acc_t d_flags,
  output acc_t q_acc,
  output acc_t q_flags
);
  generate
    if (REG_OUT) begin : g_reg
      acc_t acc_r;
      acc_t flags_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc_r   <= '0;
          flags_r <= '0;
        end else begin
          acc_r   <= d_acc;
          flags_r <= d_flags;
        end
      end
      assign q_acc   = acc_r;
      assign q_flags = flags_r;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_acc   = d_acc;
      assign q_flags = d_flags;
    end
  endgenerate
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import bcd_adjust_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] acc_in,
  input  logic       sub_in,
  input  logic       half_in,
  input  logic       carry_in,
  output logic [7:0] acc_out,
  output logic [7:0] flags_out
);
  // named internal events
  wide_t add_val;
  wide_t sub_val;
  logic  add_lo_hit;
  logic  add_lo_adj;
  logic  add_hi_hit;
  logic  sub_hi_hit;
  logic  sub_lo_adj;
  logic  sub_half_set;
  logic  sub_borrow;
  acc_t  nxt_acc;
  acc_t  nxt_flags;

  bcd_add_path u_add (
    .acc    (acc_in),
    .half   (half_in),
    .carry  (carry_in),
    .val    (add_val),
    .lo_hit (add_lo_hit),
    .lo_adj (add_lo_adj),
    .hi_hit (add_hi_hit)
  );

  bcd_sub_path u_sub (
    .acc      (acc_in),
    .half     (half_in),
    .carry    (carry_in),
    .val      (sub_val),
    .hi_hit   (sub_hi_hit),
    .lo_adj   (sub_lo_adj),
    .half_set (sub_half_set),
    .borrow   (sub_borrow)
  );

  bcd_flag_gen u_flags (
    .sub     (sub_in),
    .add_val (add_val),
    .add_h   (add_lo_hit),
    .add_c   (add_hi_hit),
    .sub_val (sub_val),
    .sub_h   (sub_half_set),
    .sub_c   (sub_hi_hit | sub_borrow),
    .res     (nxt_acc),
    .flags   (nxt_flags)
  );

  bcd_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_acc   (nxt_acc),
    .d_flags (nxt_flags),
    .q_acc   (acc_out),
    .q_flags (flags_out)
  );
endmodule

// File: rtl/bcd_adjust_chk.sv
module bcd_adjust_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] acc_in,
  input logic       sub_in,
  input logic       half_in,
  input logic       carry_in,
  input logic [7:0] acc_out,
  input logic [7:0] flags_out,
  input logic [7:0] nxt_acc,
  input logic [7:0] nxt_flags,
  input logic       add_lo_adj,
  input logic       sub_lo_adj
);
  // R1
  sub_flag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_flags[1] == sub_in);

  // R1
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_flags[5] == 1'b0) && (nxt_flags[3] == 1'b0));

  // R2
  add_lo_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_in && acc_in[3:0] >= 4'd10) |-> nxt_flags[4]);

  // R2
  add_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_in && acc_in[3:0] < 4'd10) |-> !nxt_flags[4]);

  // R3
  add_carry_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_in && carry_in) |-> nxt_flags[0]);

  // R4
  sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_in && (acc_in > 8'h99 || carry_in)) |-> nxt_flags[0]);

  // R5
  sub_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_in && acc_in[3:0] >= 4'd6) |-> !nxt_flags[4]);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_flags[6] == (nxt_acc == 8'h00));

  // R7
  no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_in && !(sub_in ? sub_lo_adj : add_lo_adj) && acc_in < 8'h9A)
      |-> (nxt_acc == acc_in));

  generate
    if (REG_OUT) begin : g_lat
      // R8
      out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (acc_out == $past(nxt_acc)) && (flags_out == $past(nxt_flags)));
    end
  endgenerate
endmodule

bind bcd_adjust bcd_adjust_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_in     (acc_in),
  .sub_in     (sub_in),
  .half_in    (half_in),
  .carry_in   (carry_in),
  .acc_out    (acc_out),
  .flags_out  (flags_out),
  .nxt_acc    (nxt_acc),
  .nxt_flags  (nxt_flags),
  .add_lo_adj (add_lo_adj),
  .sub_lo_adj (sub_lo_adj)
);

// File: tb/bcd_adjust_tb.sv
module bcd_adjust_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_in = '0;
  logic       sub_in = 1'b0;
  logic       half_in = 1'b0;
  logic       carry_in = 1'b0;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bcd_adjust u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_in    (acc_in),
    .sub_in    (sub_in),
    .half_in   (half_in),
    .carry_in  (carry_in),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  // {sub, half, carry, acc_in, exp_acc, exp_flags}
  // flags: S7 Z6 H4 P2 N1 C0
  localparam int NVEC = 16;
  localparam logic [26:0] VEC [NVEC] = '{
    {3'b000, 8'h15, 8'h15, 8'h00},   // R7 add no fix
    {3'b000, 8'h3C, 8'h42, 8'h14},   // R2 low nibble >= 10
    {3'b010, 8'h11, 8'h17, 8'h04},   // R2 half only
    {3'b000, 8'h9A, 8'h00, 8'h55},   // R3 intermediate reaches 0xA0
    {3'b001, 8'h20, 8'h80, 8'h81},   // R3 carry in
    {3'b000, 8'hB3, 8'h13, 8'h01},   // R3 raw high digit
    {3'b010, 8'h99, 8'h9F, 8'h84},   // R3 intermediate 0x9F stays
    {3'b000, 8'hA0, 8'h00, 8'h45},   // R3 exactly 0xA0, R6 zero
    {3'b000, 8'h00, 8'h00, 8'h44},   // R6 zero add
    {3'b100, 8'h15, 8'h15, 8'h02},   // R7 sub no fix, R1 N
    {3'b110, 8'h0F, 8'h09, 8'h06},   // R5 half, nibble >= 6
    {3'b110, 8'h12, 8'h0C, 8'h16},   // R5 half, nibble < 6
    {3'b101, 8'hE0, 8'h80, 8'h83},   // R4 carry in
    {3'b100, 8'h9A, 8'h34, 8'h03},   // R4 above 0x99
    {3'b111, 8'h03, 8'h9D, 8'h93},   // R4 negative intermediate
    {3'b100, 8'h00, 8'h00, 8'h46}    // R6 zero sub
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // independent reference: one total correction constant per path
  task automatic ref_model(input logic [7:0] a, input logic s, input logic h,
                           input logic c, output logic [7:0] ra, output logic [7:0] rf);
    int lo, corr, v;
    logic ho, co;
    lo = int'(a[3:0]); corr = 0; ho = 1'b0; co = 1'b0;
    if (!s) begin
      if (lo > 9) begin corr = 6; ho = 1'b1; end
      else if (h) corr = 6;
      if ((int'(a) + corr) >= 160 || c) begin corr += 96; co = 1'b1; end
      v = int'(a) + corr;
    end else begin
      if (int'(a) > 153 || c) begin corr = 96; co = 1'b1; end
      if (lo > 9 || h) begin
        corr += 6;
        ho = (lo < 6);
        if ((int'(a) - corr) < 0 && !h) co = 1'b1;
      end
      v = int'(a) - corr;
    end
    ra = v[7:0];
    rf = {ra[7], (ra == 8'h00), 1'b0, ho, 1'b0, ~(^ra), s, co};
  endtask

  task automatic apply(input logic s, input logic h, input logic c, input logic [7:0] a);
    @(negedge clk);
    sub_in = s; half_in = h; carry_in = c; acc_in = a;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] ea, ef;
    // R8 reset state
    acc_in = 8'h9A;
    repeat (3) @(negedge clk);
    check("R8 reset acc", acc_out, 8'h00);
    check("R8 reset flags", flags_out, 8'h00);
    rst_n = 1'b1;

    // table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16]);
      check($sformatf("R1-R7 table acc vec%0d", i), acc_out, VEC[i][15:8]);
      check($sformatf("R1-R7 table flags vec%0d", i), flags_out, VEC[i][7:0]);
    end

    // R8 latency: new inputs not visible before the next edge
    apply(1'b0, 1'b0, 1'b0, 8'h15);
    @(negedge clk);
    sub_in = 1'b1; carry_in = 1'b1; acc_in = 8'hE0;
    #1;
    check("R8 hold acc", acc_out, 8'h15);
    check("R8 hold flags", flags_out, 8'h00);
    @(negedge clk);
    check("R8 update acc", acc_out, 8'h80);
    check("R8 update flags", flags_out, 8'h83);

    // R8 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 midrun reset acc", acc_out, 8'h00);
    check("R8 midrun reset flags", flags_out, 8'h00);
    rst_n = 1'b1;

    // full sweep: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 2048; v++) begin
      logic [10:0] bits;
      bits = v[10:0];
      apply(bits[10], bits[9], bits[8], bits[7:0]);
      ref_model(bits[7:0], bits[10], bits[9], bits[8], ea, ef);
      check($sformatf("R2_R5 sweep acc %03h", bits), acc_out, ea);
      check($sformatf("R1_R6 sweep flags %03h", bits), flags_out, ef);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule